// File: doc/BRIEF.md
# Chunked Store-and-Forward Memory Copy Engine

The engine copies a contiguous region of memory to another address. Software loads a source address, a destination address and a byte count through a small register port, then sets a start bit. The copy runs as a loop of chunks. Each chunk is fetched completely from the source with one incrementing read burst into an on-block staging buffer. It is then sent completely from that buffer to the destination with one incrementing write burst. Reads and writes never run at the same time.

A chunk holds at most 32 beats of 16 bytes, which is 512 bytes. That matches the largest read request an upstream link will accept. A chunk is made shorter when it is the last one, or when a full chunk would run across a 4 KB page on either side. When the write response of the final chunk arrives, a sticky interrupt rises. Software clears it by writing a one to a status bit.

Top module: `dma_chunk_copy`

## Requirements
- R1: After reset the engine is idle. `irq` is low, status reads 0, and every request valid and every ready output of the master ports is low.
- R2: Register index 0 holds the source address, index 1 the destination address and index 2 the byte count. Each reads back the value last written to it.
- R3: While the engine is busy, writes to register indices 0, 1 and 2 are ignored, and their readback keeps the earlier value.
- R4: Each read and each write burst carries N beats, with `ar_len`/`aw_len` equal to N-1. N is the smallest of four values: the beats still remaining, 32, the beats left before the next 4 KB page on the source side, and the same count on the destination side.
- R5: No read or write burst crosses a 4 KB address boundary.
- R6: The first burst uses the programmed addresses. After each chunk, both the source and the destination address advance by 16 times that chunk's beat count.
- R7: A chunk's write address is issued only after all beats of its read burst have been accepted. The write data beats equal the read data beats of the same chunk, in the same order. Read and write channels are never active together.
- R8: The byte count is rounded up to whole 16-byte beats. For example, 100 bytes moves 7 beats.
- R9: `irq` rises on the clock edge at which the final chunk's write response is accepted, never earlier. Busy (status bit 0) clears on that same edge.
- R10: `irq` stays high until a write to register index 3 with bit 1 set clears it. Status bit 1 reflects `irq`.
- R11: Starting with a byte count of 0 raises `irq` on the start edge and issues no bus transaction.
- R12: Writing the start bit (index 3, bit 0) while busy is ignored. The running transfer moves exactly its own beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register index: 0 source, 1 destination, 2 byte count, 3 control/status |
| cfg_wdata | input | 32 | Register write data. At index 3, bit 0 starts and bit 1 clears `irq` |
| cfg_rdata | output | 32 | Read data for `cfg_sel`. At index 3, bit 0 is busy and bit 1 is `irq` |
| irq | output | 1 | Sticky completion interrupt |
| ar_valid | output | 1 | Read address valid |
| ar_ready | input | 1 | Read address ready |
| ar_addr | output | ADDR_W | Read burst start address |
| ar_len | output | 8 | Read burst beats minus one |
| r_valid | input | 1 | Read data valid |
| r_ready | output | 1 | Read data ready |
| r_data | input | DATA_W | Read data beat |
| aw_valid | output | 1 | Write address valid |
| aw_ready | input | 1 | Write address ready |
| aw_addr | output | ADDR_W | Write burst start address |
| aw_len | output | 8 | Write burst beats minus one |
| w_valid | output | 1 | Write data valid |
| w_ready | input | 1 | Write data ready |
| w_data | output | DATA_W | Write data beat |
| w_last | output | 1 | Final beat of the write burst |
| b_valid | input | 1 | Write response valid |
| b_ready | output | 1 | Write response ready |

## Verification
A wrong remaining-beat count or a wrong address register shows on the very next address handshake as an unexpected `ar_len` or `ar_addr`. A bad count may also surface as an early or late `irq`. A staging buffer that is misindexed shows within the same chunk, because a write data beat will not match the source pattern at its offset. A phase sequencer that lets the write start early shows as an address-write handshake before the read burst has drained.

// File: rtl/dma_chunk_copy.sv
module dma_chunk_copy #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 128,
  parameter int MAX_BEATS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic              irq,
  output logic              ar_valid,
  input  logic              ar_ready,
  output logic [ADDR_W-1:0] ar_addr,
  output logic [7:0]        ar_len,
  input  logic              r_valid,
  output logic              r_ready,
  input  logic [DATA_W-1:0] r_data,
  output logic              aw_valid,
  input  logic              aw_ready,
  output logic [ADDR_W-1:0] aw_addr,
  output logic [7:0]        aw_len,
  output logic              w_valid,
  input  logic              w_ready,
  output logic [DATA_W-1:0] w_data,
  output logic              w_last,
  input  logic              b_valid,
  output logic              b_ready
);
  localparam int BEAT_B = DATA_W / 8;
  localparam int BSH    = $clog2(BEAT_B);
  localparam int BI_W   = $clog2(MAX_BEATS);
  localparam int IDX_W  = BI_W + 1;
  localparam int REM_W  = 33 - BSH;

  typedef enum logic [2:0] {S_IDLE, S_AR, S_R, S_AW, S_W, S_B} state_t;
  state_t state;

  logic [ADDR_W-1:0] src_r, dst_r, cur_src, cur_dst;
  logic [31:0]       size_r;
  logic [REM_W-1:0]  rem, lim;
  logic [IDX_W-1:0]  idx, nb;
  logic [DATA_W-1:0] stage [MAX_BEATS];
  logic [12:0]       s_room, d_room;
  logic              busy, last_beat;

  assign busy      = state != S_IDLE;
  assign s_room    = 13'h1000 - {1'b0, cur_src[11:0]};
  assign d_room    = 13'h1000 - {1'b0, cur_dst[11:0]};

  always_comb begin
    lim = rem;
    if (lim > REM_W'(MAX_BEATS)) lim = REM_W'(MAX_BEATS);
    if (lim > REM_W'(s_room >> BSH)) lim = REM_W'(s_room >> BSH);
    if (lim > REM_W'(d_room >> BSH)) lim = REM_W'(d_room >> BSH);
  end

  assign nb        = lim[IDX_W-1:0];
  assign last_beat = idx == nb - IDX_W'(1);

  assign ar_valid  = state == S_AR;
  assign ar_addr   = cur_src;
  assign ar_len    = 8'(nb - IDX_W'(1));
  assign r_ready   = state == S_R;
  assign aw_valid  = state == S_AW;
  assign aw_addr   = cur_dst;
  assign aw_len    = 8'(nb - IDX_W'(1));
  assign w_valid   = state == S_W;
  assign w_data    = stage[idx[BI_W-1:0]];
  assign w_last    = w_valid && last_beat;
  assign b_ready   = state == S_B;

  always_comb begin
    case (cfg_sel)
      2'd0:    cfg_rdata = 32'(src_r);
      2'd1:    cfg_rdata = 32'(dst_r);
      2'd2:    cfg_rdata = size_r;
      default: cfg_rdata = {30'd0, irq, busy};
    endcase
  end

  always_ff @(posedge clk)
    if (r_valid && r_ready) stage[idx[BI_W-1:0]] <= r_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      irq     <= 1'b0;
      src_r   <= '0;
      dst_r   <= '0;
      size_r  <= '0;
      cur_src <= '0;
      cur_dst <= '0;
      rem     <= '0;
      idx     <= '0;
    end else begin
      case (state)
        S_AR: if (ar_ready) begin
          state <= S_R;
          idx   <= '0;
        end
        S_R: if (r_valid) begin
          idx <= idx + IDX_W'(1);
          if (last_beat) begin
            state <= S_AW;
            idx   <= '0;
          end
        end
        S_AW: if (aw_ready) state <= S_W;
        S_W: if (w_ready) begin
          idx <= idx + IDX_W'(1);
          if (last_beat) state <= S_B;
        end
        S_B: if (b_valid) begin
          cur_src <= cur_src + (ADDR_W'(nb) << BSH);
          cur_dst <= cur_dst + (ADDR_W'(nb) << BSH);
          rem     <= rem - REM_W'(nb);
          if (rem == REM_W'(nb)) begin
            state <= S_IDLE;
            irq   <= 1'b1;
          end else begin
            state <= S_AR;
          end
        end
        default: ;
      endcase

      if (cfg_we) begin
        case (cfg_sel)
          2'd0: if (!busy) src_r <= cfg_wdata[ADDR_W-1:0];
          2'd1: if (!busy) dst_r <= cfg_wdata[ADDR_W-1:0];
          2'd2: if (!busy) size_r <= cfg_wdata;
          default: begin
            if (cfg_wdata[1]) irq <= 1'b0;
            if (cfg_wdata[0] && !busy) begin
              if (size_r == 32'd0) begin
                irq <= 1'b1;
              end else begin
                cur_src <= src_r;
                cur_dst <= dst_r;
                rem     <= REM_W'(({1'b0, size_r} + 33'(BEAT_B - 1)) >> BSH);
                state   <= S_AR;
              end
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/dma_chunk_copy_chk.sv
module dma_chunk_copy_chk #(
  parameter int ADDR_W    = 32,
  parameter int MAX_BEATS = 32,
  parameter int BSH       = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [1:0]        cfg_sel,
  input logic [31:0]       cfg_wdata,
  input logic              irq,
  input logic              busy,
  input logic              ar_valid,
  input logic              ar_ready,
  input logic [ADDR_W-1:0] ar_addr,
  input logic [7:0]        ar_len,
  input logic              r_ready,
  input logic              aw_valid,
  input logic [ADDR_W-1:0] aw_addr,
  input logic [7:0]        aw_len,
  input logic              w_valid,
  input logic              b_ready
);
  logic clr_wr;
  assign clr_wr = cfg_we && cfg_sel == 2'd3 && cfg_wdata[1];

  AST_BURST_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    ar_valid |-> 32'(ar_len) < MAX_BEATS); // R4
  AST_AR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ar_valid && !ar_ready |=> ar_valid && $stable(ar_addr) && $stable(ar_len)); // R4
  AST_RD_NO_4K: assert property (@(posedge clk) disable iff (!rst_n)
    ar_valid |-> 32'(ar_addr[11:0]) + ((32'(ar_len) + 32'd1) << BSH) <= 32'd4096); // R5
  AST_WR_NO_4K: assert property (@(posedge clk) disable iff (!rst_n)
    aw_valid |-> 32'(aw_addr[11:0]) + ((32'(aw_len) + 32'd1) << BSH) <= 32'd4096); // R5
  AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !((ar_valid || r_ready) && (aw_valid || w_valid || b_ready))); // R7
  AST_IRQ_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> !busy); // R9
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !clr_wr |=> irq); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(ar_valid || r_ready || aw_valid || w_valid || b_ready)); // R11
endmodule

bind dma_chunk_copy dma_chunk_copy_chk #(.ADDR_W(ADDR_W), .MAX_BEATS(MAX_BEATS), .BSH(BSH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
  .irq(irq), .busy(busy), .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_addr(ar_addr),
  .ar_len(ar_len), .r_ready(r_ready), .aw_valid(aw_valid), .aw_addr(aw_addr),
  .aw_len(aw_len), .w_valid(w_valid), .b_ready(b_ready)
);

// File: tb/sim_dma_chunk_copy.sv
`timescale 1ns/1ps
module sim_dma_chunk_copy;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic irq;
  logic ar_valid, ar_ready = 1'b0, r_valid = 1'b0, r_ready;
  logic [31:0] ar_addr, aw_addr;
  logic [7:0] ar_len, aw_len;
  logic [127:0] r_data = '0, w_data;
  logic aw_valid, aw_ready = 1'b0, w_valid, w_ready = 1'b0, w_last, b_valid = 1'b0, b_ready;

  always #2.5 clk = ~clk;

  dma_chunk_copy u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .irq(irq), .ar_valid(ar_valid), .ar_ready(ar_ready),
    .ar_addr(ar_addr), .ar_len(ar_len), .r_valid(r_valid), .r_ready(r_ready), .r_data(r_data),
    .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_addr(aw_addr), .aw_len(aw_len),
    .w_valid(w_valid), .w_ready(w_ready), .w_data(w_data), .w_last(w_last),
    .b_valid(b_valid), .b_ready(b_ready)
  );

  int tests = 0, fails = 0;
  bit finished = 0;
  int unsigned exp_src, exp_dst, exp_rem, cur_nb, rd_addr, rd_left, wr_left, w_src, w_idx;
  int unsigned n_ar, n_aw, n_rb, n_wb, cyc;
  bit b_pend = 0, irq_due = 0, stall_en = 0;

  task automatic chk(input bit ok, input string req, input longint unsigned act, input longint unsigned exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] pat(input int unsigned a);
    return {a, a ^ 32'hA5C3_5A3C, ~a, a * 32'd2654435761};
  endfunction

  function automatic int unsigned chunk_n(input int unsigned s, input int unsigned d, input int unsigned rem);
    int unsigned m = rem;
    if (m > 32) m = 32;
    if (m > (4096 - s % 4096) / 16) m = (4096 - s % 4096) / 16;
    if (m > (4096 - d % 4096) / 16) m = (4096 - d % 4096) / 16;
    return m;
  endfunction

  initial begin
    rd_left = 0; wr_left = 0; exp_rem = 0; cyc = 0;
    forever @(negedge clk) begin
      bit stall;
      cyc++;
      stall    = stall_en && (cyc % 5 == 3);
      ar_ready = (rd_left == 0) && !stall;
      r_valid  = (rd_left != 0) && !stall;
      r_data   = pat(rd_addr);
      aw_ready = (wr_left == 0) && !b_pend && !stall;
      w_ready  = (wr_left != 0) && !stall;
      b_valid  = b_pend && !stall;
      if (irq_due) begin
        chk(irq == 1'b1, "R9 irq after final response", irq, 1);
        irq_due = 0;
      end else if (irq && exp_rem != 0) begin
        chk(0, "R9 irq before final chunk", irq, 0);
      end
      #1;
      if (ar_valid && ar_ready) begin
        cur_nb = chunk_n(exp_src, exp_dst, exp_rem);
        chk(ar_addr == exp_src, "R6 read address", ar_addr, exp_src);
        chk(ar_len == 8'(cur_nb - 1), "R4 read length", ar_len, cur_nb - 1);
        rd_addr = ar_addr; rd_left = ar_len + 1; n_ar++;
      end
      if (r_valid && r_ready) begin
        rd_addr += 16; rd_left--; n_rb++;
      end
      if (aw_valid && aw_ready) begin
        chk(aw_addr == exp_dst, "R6 write address", aw_addr, exp_dst);
        chk(aw_len == 8'(cur_nb - 1), "R4 write length", aw_len, cur_nb - 1);
        chk(rd_left == 0 && n_rb - n_wb == cur_nb, "R7 read drained before write", n_rb - n_wb, cur_nb);
        wr_left = aw_len + 1; w_src = exp_src; w_idx = 0; n_aw++;
      end
      if (w_valid && w_ready) begin
        chk(w_data == pat(w_src), "R7 write data", w_data[31:0], w_src);
        chk(w_last == (wr_left == 1), "R4 write last flag", w_last, wr_left == 1);
        w_src += 16; wr_left--; n_wb++;
        if (wr_left == 0) b_pend = 1;
      end
      if (b_valid && b_ready) begin
        b_pend = 0;
        exp_src += cur_nb * 16; exp_dst += cur_nb * 16; exp_rem -= cur_nb;
        if (exp_rem == 0) irq_due = 1;
      end
    end
  end

  task automatic reg_wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] sel, output logic [31:0] d);
    @(negedge clk);
    cfg_sel = sel;
    #1 d = cfg_rdata;
  endtask

  task automatic wait_irq();
    for (int i = 0; i < 20000 && !irq; i++) @(negedge clk);
  endtask

  task automatic finish_xfer(input int unsigned size, input int unsigned chunks);
    logic [31:0] st;
    int unsigned beats = (size + 15) / 16;
    wait_irq();
    reg_rd(2'd3, st);
    chk(st == 32'd2, "R9 status after done", st, 2);
    chk(n_wb == beats && n_rb == beats, "R8 beats moved", n_wb, beats);
    chk(n_ar == chunks && n_aw == chunks, "R4 chunk count", n_ar, chunks);
    repeat (4) @(negedge clk);
    chk(n_ar == chunks && n_wb == beats, "R9 quiet after done", n_ar, chunks);
    reg_wr(2'd3, 32'd0);
    reg_rd(2'd3, st);
    chk(st == 32'd2, "R10 irq kept without clear bit", st, 2);
    reg_wr(2'd3, 32'd2);
    reg_rd(2'd3, st);
    chk(st == 32'd0, "R10 irq cleared", st, 0);
  endtask

  task automatic start_xfer(input int unsigned s, input int unsigned d, input int unsigned size);
    reg_wr(2'd0, s); reg_wr(2'd1, d); reg_wr(2'd2, size);
    exp_src = s; exp_dst = d; exp_rem = (size + 15) / 16;
    n_ar = 0; n_aw = 0; n_rb = 0; n_wb = 0;
    reg_wr(2'd3, 32'd1);
  endtask

  function automatic int unsigned count_chunks(input int unsigned s, input int unsigned d, input int unsigned size);
    int unsigned rem = (size + 15) / 16, n = 0;
    while (rem != 0) begin
      int unsigned m = chunk_n(s, d, rem);
      s += m * 16; d += m * 16; rem -= m; n++;
    end
    return n;
  endfunction

  initial begin
    logic [31:0] v;
    int unsigned sizes [6] = '{16, 100, 496, 512, 528, 1040};
    int unsigned soffs [3] = '{32'h000, 32'hF00, 32'hFF0};
    int unsigned doffs [3] = '{32'h000, 32'hE80, 32'h7F0};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    reg_rd(2'd3, v);
    chk(v == 0 && irq == 0, "R1 reset status", v, 0);
    chk(!ar_valid && !aw_valid && !w_valid && !r_ready && !b_ready, "R1 reset bus idle", ar_valid, 0);

    reg_wr(2'd0, 32'h1234_5670); reg_wr(2'd1, 32'h0BAD_F000); reg_wr(2'd2, 32'd777);
    reg_rd(2'd0, v); chk(v == 32'h1234_5670, "R2 source readback", v, 32'h1234_5670);
    reg_rd(2'd1, v); chk(v == 32'h0BAD_F000, "R2 destination readback", v, 32'h0BAD_F000);
    reg_rd(2'd2, v); chk(v == 32'd777, "R2 size readback", v, 777);

    start_xfer(32'h0001_0000, 32'h0008_0000, 0);
    chk(irq == 1'b1, "R11 zero size irq on start edge", irq, 1);
    repeat (4) @(negedge clk);
    chk(n_ar == 0 && n_aw == 0, "R11 zero size no bus traffic", n_ar + n_aw, 0);
    reg_rd(2'd3, v); chk(v == 32'd2, "R11 zero size status", v, 2);
    reg_wr(2'd3, 32'd2);

    start_xfer(32'h0002_0000, 32'h0009_0000, 100);
    finish_xfer(100, 1);

    for (int si = 0; si < 3; si++)
      for (int di = 0; di < 3; di++)
        for (int zi = 0; zi < 6; zi++) begin
          int unsigned s = 32'h0004_0000 + soffs[si];
          int unsigned d = 32'h000C_0000 + doffs[di];
          stall_en = ((si + di + zi) % 2) == 1;
          start_xfer(s, d, sizes[zi]);
          finish_xfer(sizes[zi], count_chunks(s, d, sizes[zi]));
        end

    stall_en = 1;
    start_xfer(32'h0010_0000, 32'h0020_0000, 4096);
    repeat (10) @(negedge clk);
    reg_wr(2'd0, 32'hDEAD_0000); reg_wr(2'd1, 32'hBEEF_0000); reg_wr(2'd2, 32'd16);
    reg_rd(2'd0, v); chk(v == 32'h0010_0000, "R3 source write ignored while busy", v, 32'h0010_0000);
    reg_rd(2'd1, v); chk(v == 32'h0020_0000, "R3 destination write ignored while busy", v, 32'h0020_0000);
    reg_rd(2'd2, v); chk(v == 32'd4096, "R3 size write ignored while busy", v, 4096);
    reg_rd(2'd3, v); chk(v[0] == 1'b1, "R3 busy flag", v[0], 1);
    reg_wr(2'd3, 32'd1);
    finish_xfer(4096, 8);
    chk(n_wb == 256, "R12 restart while busy ignored", n_wb, 256);

    stall_en = 0;
    start_xfer(32'h0030_0000, 32'h0040_0000, 8192);
    finish_xfer(8192, 16);

    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog: run did not complete actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule